// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a down-counting watchdog that runs from its own slow counter clock while software reaches it through a small word-addressed register bank on the system bus clock. Commands go through a key register. One magic value opens the prescaler and reload registers for writing. A second value starts the counter. A third value reloads the counter, which is the periodic "kick" that software must keep sending. After the watchdog has started, no register access can halt it. If software stops kicking, the counter runs down and the block raises a single-cycle reset request in the counter clock domain.

The prescaler and reload settings are written in the bus domain and cross into the counter domain through toggle handshakes. Two status bits stay set while such a transfer is in flight. Software polls them before it relies on a new setting. Both domains must be reset together.

Top module: `kwdt_top`

## Requirements
- R1: After reset the prescaler field reads 0, the reload field reads 0xFFF, the status reads 0 and the reset request stays low.
- R2: The byte address `bus_addr[3:0]` decodes as follows: 0x0 is the key register (write-only, reads 0), 0x4 is the prescaler, 0x8 is the reload value and 0xC is the status. Every other address reads 0.
- R3: A key write whose low 16 bits equal 0x5555 (upper bits are not compared) opens the prescaler and reload registers for writing. Any other key write closes them again. Writes to those registers while they are closed leave them unchanged.
- R4: The prescaler field is `bus_wdata[PR_W-1:0]` and selects a divide ratio of 4·2^PR. A value above log2(MAX_DIV)−2 is stored as that maximum (6 when MAX_DIV is 256). The reload field is `bus_wdata[11:0]`.
- R5: Status bit 0 (prescaler update pending) and bit 1 (reload update pending) are set in the cycle after an accepted write. Each clears after the new value has reached the counter domain. A write to a register whose update is still pending is ignored.
- R6: A key value of 0xCCCC starts the watchdog. Until the watchdog has started, no reset request is produced.
- R7: While the watchdog runs without kicks, reset request pulses are each one counter-clock cycle wide and are spaced max(RLR,1)·4·2^PR counter-clock cycles apart.
- R8: A key value of 0xAAAA reloads the counter and the prescaler, which postpones the next reset request. When kicks stop, requests resume.
- R9: No key or register write stops a started watchdog. Only reset stops it.
- R10: Key values that are not commands have no effect apart from closing the configuration registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wd_clk | input | 1 | Independent counter clock |
| wd_rst_n | input | 1 | Counter-domain synchronous active-low reset |
| wdg_rst_req | output | 1 | Reset request pulse, one `wd_clk` cycle |

## Verification
Register readback is combinational, and a pending flag rises at the bus edge that accepts the write. The bench therefore reads status right after the write's capturing edge, and it reads stored values right after the address is set. The time a setting needs to cross, or a command needs to act, depends on the ratio of the two clocks. For that reason the bench never waits a fixed number of cycles. It polls status until the flags clear, and it judges expiry timing only from the spacing between the second and third pulses after a kick, counted in counter-clock cycles. The first interval after a kick is partial, so it is never used for a timing check.

// File: rtl/kwdt_pkg.sv
// Shared constants for the keyed watchdog: command keys, register
// offsets and indices of the signals that cross into the counter domain.
package kwdt_pkg;
    localparam logic [15:0] KEY_UNLOCK = 16'h5555;
    localparam logic [15:0] KEY_START  = 16'hCCCC;
    localparam logic [15:0] KEY_KICK   = 16'hAAAA;

    localparam logic [3:0] OFS_KEY = 4'h0;
    localparam logic [3:0] OFS_PR  = 4'h4;
    localparam logic [3:0] OFS_RL  = 4'h8;
    localparam logic [3:0] OFS_ST  = 4'hC;

    localparam int IX_PR    = 0;
    localparam int IX_RL    = 1;
    localparam int IX_START = 2;
    localparam int IX_KICK  = 3;
    localparam int N_XING   = 4;
endpackage

// File: rtl/kwdt_sync.sv
// Multi-stage flop synchronizer for level or toggle signals.
// Assumes every bit is a slow level or a toggle that changes at most
// once per several destination cycles.
module kwdt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the input through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/kwdt_regs.sv
// Bus-domain register bank: key decoding, write gate, prescaler and
// reload storage, pending flags, and the command toggles.
// Assumes the acknowledge toggles arrive already synchronized to clk.
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int RL_W   = 12,
    parameter int PR_W   = 3,
    parameter int PR_MAX = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [3:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [1:0]      ack_s,
    output logic [N_XING-1:0] req_tgl,
    output logic [PR_W-1:0] pr_q,
    output logic [RL_W-1:0] rl_q
);
    logic            unlocked;
    logic            key_wr;
    logic [15:0]     key;
    logic            pr_pend, rl_pend;
    logic            pr_wr_ok, rl_wr_ok;
    logic [PR_W-1:0] pr_in, pr_clamped;

    assign key_wr     = bus_wr && (bus_addr == OFS_KEY);
    assign key        = bus_wdata[15:0];
    assign pr_pend    = req_tgl[IX_PR] ^ ack_s[0];
    assign rl_pend    = req_tgl[IX_RL] ^ ack_s[1];
    assign pr_wr_ok   = bus_wr && (bus_addr == OFS_PR) && unlocked && !pr_pend;
    assign rl_wr_ok   = bus_wr && (bus_addr == OFS_RL) && unlocked && !rl_pend;
    assign pr_in      = bus_wdata[PR_W-1:0];
    assign pr_clamped = (pr_in > PR_W'(PR_MAX)) ? PR_W'(PR_MAX) : pr_in;

    // Register writes, write gate and command toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            pr_q     <= '0;
            rl_q     <= '1;
            req_tgl  <= '0;
        end else begin
            if (key_wr) unlocked <= (key == KEY_UNLOCK);
            if (pr_wr_ok) begin
                pr_q           <= pr_clamped;
                req_tgl[IX_PR] <= ~req_tgl[IX_PR];
            end
            if (rl_wr_ok) begin
                rl_q           <= bus_wdata[RL_W-1:0];
                req_tgl[IX_RL] <= ~req_tgl[IX_RL];
            end
            if (key_wr && key == KEY_START) req_tgl[IX_START] <= ~req_tgl[IX_START];
            if (key_wr && key == KEY_KICK)  req_tgl[IX_KICK]  <= ~req_tgl[IX_KICK];
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PR:  bus_rdata[PR_W-1:0] = pr_q;
            OFS_RL:  bus_rdata[RL_W-1:0] = rl_q;
            OFS_ST:  bus_rdata[1:0]      = {rl_pend, pr_pend};
            default: bus_rdata = '0;
        endcase
    end

    // R3: closed registers hold their value through a write.
    a_r3_locked_pr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PR && !unlocked) |=> $stable(pr_q));
    // R4: the stored prescaler never exceeds its maximum.
    a_r4_pr_range: assert property (@(posedge clk) disable iff (!rst_n)
        pr_q <= PR_W'(PR_MAX));
    // R5: a reload value in flight does not change.
    a_r5_rl_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rl_pend |=> $stable(rl_q));
endmodule

// File: rtl/kwdt_core.sv
// Counter-domain engine: takes the settings, detects the start and kick
// commands, runs the prescaler and down counter, and pulses a reset
// request on expiry. Assumes the request toggles are synchronized and
// that the setting values stay stable while their toggles are in flight.
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int RL_W  = 12,
    parameter int PR_W  = 3,
    parameter int PSC_W = 8
) (
    input  logic              wd_clk,
    input  logic              wd_rst_n,
    input  logic [N_XING-1:0] req_s,
    input  logic [PR_W-1:0]   pr_val,
    input  logic [RL_W-1:0]   rl_val,
    output logic [1:0]        ack,
    output logic              rst_req
);
    logic [N_XING-1:0] seen, ev;
    logic [PR_W-1:0]   sh_pr;
    logic [RL_W-1:0]   sh_rl;
    logic [PSC_W-1:0]  psc;
    logic [RL_W-1:0]   cnt;
    logic              running;
    logic              load;
    logic              tick;
    logic [PSC_W:0]    div_full;

    assign ev       = req_s ^ seen;
    assign load     = ev[IX_START] || (ev[IX_KICK] && running);
    assign div_full = (PSC_W+1)'(4) << sh_pr;
    assign tick     = psc >= PSC_W'(div_full - 1'b1);
    assign ack      = seen[1:0];

    // Settings capture, prescaler, down counter and expiry pulse.
    always_ff @(posedge wd_clk) begin
        if (!wd_rst_n) begin
            seen    <= '0;
            sh_pr   <= '0;
            sh_rl   <= '1;
            psc     <= '0;
            cnt     <= '1;
            running <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            seen    <= req_s;
            rst_req <= 1'b0;
            if (ev[IX_PR]) sh_pr <= pr_val;
            if (ev[IX_RL]) sh_rl <= rl_val;
            if (load) begin
                running <= 1'b1;
                cnt     <= sh_rl;
                psc     <= '0;
            end else if (running) begin
                if (tick) begin
                    psc <= '0;
                    if (cnt <= RL_W'(1)) begin
                        cnt     <= sh_rl;
                        rst_req <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    psc <= psc + 1'b1;
                end
            end
        end
    end

    // R7: each request lasts one counter cycle.
    a_r7_pulse_single: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        rst_req |=> !rst_req);
    // R6: requests only come from a started watchdog.
    a_r6_pulse_needs_start: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        rst_req |-> running);
    // R9: once started, the watchdog keeps running.
    a_r9_running_sticky: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        running |=> running);
endmodule

// File: rtl/kwdt_top.sv
// Keyed independent watchdog: bus-domain register bank, toggle
// synchronizers in both directions, and the counter-domain engine.
// Assumes rst_n and wd_rst_n are asserted together.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int RL_W    = 12,
    parameter int MAX_DIV = 256,
    parameter int STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        wd_clk,
    input  logic        wd_rst_n,
    output logic        wdg_rst_req
);
    localparam int PSC_W  = $clog2(MAX_DIV);
    localparam int PR_MAX = PSC_W - 2;
    localparam int PR_W   = $clog2(PR_MAX + 1);

    logic [N_XING-1:0] req_tgl, req_s;
    logic [1:0]        ack, ack_s;
    logic [PR_W-1:0]   pr_q;
    logic [RL_W-1:0]   rl_q;

    kwdt_regs #(.RL_W(RL_W), .PR_W(PR_W), .PR_MAX(PR_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_s(ack_s),
        .req_tgl(req_tgl), .pr_q(pr_q), .rl_q(rl_q)
    );

    kwdt_sync #(.WIDTH(N_XING), .STAGES(STAGES)) u_to_wd (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(req_tgl), .q(req_s)
    );

    kwdt_sync #(.WIDTH(2), .STAGES(STAGES)) u_to_bus (
        .clk(clk), .rst_n(rst_n), .d(ack), .q(ack_s)
    );

    kwdt_core #(.RL_W(RL_W), .PR_W(PR_W), .PSC_W(PSC_W)) u_core (
        .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .req_s(req_s),
        .pr_val(pr_q), .rl_val(rl_q), .ack(ack), .rst_req(wdg_rst_req)
    );
endmodule

// File: tb/kwdt_top_tb.sv
// Self-checking bench for kwdt_top: register rules, then a sweep of
// expiry periods computed as max(RLR,1)*4*2^PR counter cycles.
module kwdt_top_tb;
    logic        clk = 1'b0, wd_clk = 1'b0;
    logic        rst_n = 1'b0, wd_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdg_rst_req;

    int checks = 0, errors = 0;
    int lsi_cyc = 0, last_pulse = 0, last_gap = 0, pulse_cnt = 0;
    int bus_cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always #13 wd_clk = ~wd_clk;

    kwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_clk(wd_clk),
        .wd_rst_n(wd_rst_n), .wdg_rst_req(wdg_rst_req)
    );

    // Pulse monitor, sampled away from the counter clock's active edge.
    always @(negedge wd_clk) begin
        lsi_cyc++;
        if (wdg_rst_req === 1'b1) begin
            last_gap   = lsi_cyc - last_pulse;
            last_pulse = lsi_cyc;
            pulse_cnt++;
        end
    end

    // Watchdog on the bench itself.
    always @(posedge clk) begin
        bus_cyc++;
        if (bus_cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: run hung, act %0d cycles exp < 150000", bus_cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_settled();
        logic [31:0] s;
        int n = 0;
        rd(4'hC, s);
        while (s[1:0] != 2'b00 && n < 200) begin
            @(negedge clk);
            rd(4'hC, s);
            n++;
        end
        chk(s[1:0] == 2'b00, "R5 flags clear", int'(s), 0);
    endtask

    task automatic configure(input int pr, input int rl);
        wr(4'h0, 32'h5555);
        wr(4'h4, pr);
        wr(4'h8, rl);
        wait_settled();
    endtask

    task automatic measure(input int exp, input string req);
        int p0, n;
        wr(4'h0, 32'hAAAA);
        p0 = pulse_cnt;
        n  = 0;
        while (pulse_cnt < p0 + 3 && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk(last_gap == exp, req, last_gap, exp);
    endtask

    initial begin
        logic [31:0] v;
        int p0;
        idle(3);
        rst_n = 1'b1; wd_rst_n = 1'b1;
        idle(2);

        // R1 reset state and R2 map
        rd(4'h4, v); chk(v == 0, "R1 PR reset", int'(v), 0);
        rd(4'h8, v); chk(v == 32'hFFF, "R1 RLR reset", int'(v), 32'hFFF);
        rd(4'hC, v); chk(v == 0, "R1 status reset", int'(v), 0);
        rd(4'h0, v); chk(v == 0, "R2 key reads 0", int'(v), 0);
        rd(4'h2, v); chk(v == 0, "R2 unmapped reads 0", int'(v), 0);

        // R3 closed registers ignore writes
        wr(4'h8, 32'h123);
        rd(4'h8, v); chk(v == 32'hFFF, "R3 locked RLR", int'(v), 32'hFFF);
        rd(4'hC, v); chk(v == 0, "R3 no pending after locked write", int'(v), 0);

        // R10 unknown key relocks
        wr(4'h0, 32'h5555);
        wr(4'h0, 32'h1234);
        wr(4'h4, 32'h2);
        rd(4'h4, v); chk(v == 0, "R10 relocked PR", int'(v), 0);

        // R3 only the low 16 bits are compared
        wr(4'h0, 32'hABCD5555);
        wr(4'h8, 32'h2A);
        rd(4'hC, v); chk(v[1:0] == 2'b10, "R5 RLR pending set", int'(v), 2);
        rd(4'h8, v); chk(v == 32'h2A, "R3 unlocked RLR", int'(v), 32'h2A);
        // R5 write while pending is ignored
        wr(4'h8, 32'h77);
        rd(4'h8, v); chk(v == 32'h2A, "R5 pending write ignored", int'(v), 32'h2A);
        wait_settled();

        // R4 prescaler saturation
        wr(4'h4, 32'h7);
        rd(4'hC, v); chk(v[1:0] == 2'b01, "R5 PR pending set", int'(v), 1);
        wait_settled();
        rd(4'h4, v); chk(v == 6, "R4 PR clamp", int'(v), 6);

        // R6 nothing before start
        configure(0, 3);
        idle(300);
        chk(pulse_cnt == 0, "R6 no pulse before start", pulse_cnt, 0);
        wr(4'h0, 32'hCCCC);
        idle(300);
        chk(pulse_cnt > 0, "R6 pulses after start", pulse_cnt, 1);

        // R7 period sweep
        for (int pr = 0; pr < 3; pr++) begin
            for (int k = 0; k < 5; k++) begin
                int rl, exp;
                rl  = (k == 4) ? 5 : k;
                exp = ((rl == 0) ? 1 : rl) * (4 << pr);
                configure(pr, rl);
                measure(exp, "R7 period");
            end
        end
        configure(7, 1);
        measure(256, "R7 R4 saturated period");

        // R8 kicks postpone expiry
        configure(0, 40);
        wr(4'h0, 32'hAAAA);
        idle(20);
        p0 = pulse_cnt;
        for (int i = 0; i < 20; i++) begin
            wr(4'h0, 32'hAAAA);
            idle(148);
        end
        chk(pulse_cnt == p0, "R8 kicked no pulse", pulse_cnt, p0);
        idle(800);
        chk(pulse_cnt > p0, "R8 expiry resumes", pulse_cnt, p0 + 1);

        // R9 nothing stops it
        wr(4'h0, 32'h0);
        wr(4'h0, 32'h5555);
        wr(4'h0, 32'hFFFF);
        p0 = pulse_cnt;
        idle(1200);
        chk(pulse_cnt > p0, "R9 still running", pulse_cnt, p0 + 1);

        // R9 reset stops it, R1 values return
        @(negedge clk);
        rst_n = 1'b0; wd_rst_n = 1'b0;
        idle(10);
        rst_n = 1'b1; wd_rst_n = 1'b1;
        idle(2);
        p0 = pulse_cnt;
        idle(1500);
        chk(pulse_cnt == p0, "R9 reset stops", pulse_cnt, p0);
        rd(4'h8, v); chk(v == 32'hFFF, "R1 RLR after reset", int'(v), 32'hFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule